// File: doc/BRIEF.md
# Burst SRAM Command Decoder

This block sits at the control edge of a pipelined burst static RAM. On every rising clock edge it samples three chip selects, two address strobes (one for a processor, one for a cache controller), a burst-advance input and the write-enable group. From these it decides whether the edge starts a read, starts a write, deselects the array, advances the current burst or holds it. It also works out which of the two byte lanes receive a write strobe.

The two strobes are not symmetric. The processor strobe is gated by the master select and always starts a read. The controller strobe is honoured whatever the master select says. It is recognised only when the processor strobe is not taking the edge, and it may start either a read or a write. Between strobes the decoder remembers whether the open burst is a read or a write. The address sequencer and the output data path use its four registered results: an address-load pulse, a burst-advance pulse, a per-lane write mask and a write-burst flag.

Top module: `sramCmdDecoder`

## Requirements
- R1: While reset is asserted, and after its release until the first decision, addrLoad, burstCont, wrBurst and both wrMask bits are 0.
- R2: An edge with cpuStrobeN low, masterSelN low, selHi high and selLoN low starts a read, whatever hostStrobeN and the write enables are. The result is addrLoad=1, wrMask=00 and wrBurst=0.
- R3: cpuStrobeN low while masterSelN is high is ignored. If hostStrobeN is high, the edge behaves as a non-strobe edge of the open burst.
- R4: hostStrobeN low while masterSelN is high is accepted and deselects. The result is addrLoad=0 and wrBurst=0, and the burst is closed.
- R5: A controller-strobe start (hostStrobeN low, processor strobe not taking the edge) with all selects active and a write selected gives addrLoad=1 and wrBurst=1. wrMask bit i is 1 when allBytesWrN is low, or when laneWrEnN and laneSelN[i] are both low.
- R6: A controller-strobe start with all selects active and no lane selected for writing starts a read: addrLoad=1, wrMask=00, wrBurst=0.
- R7: An accepted strobe with selHi low or selLoN high deselects: addrLoad=0, wrBurst=0, and the burst is closed.
- R8: On an edge with no accepted strobe and an open burst, advanceN low gives burstCont=1 and advanceN high gives burstCont=0 (suspend). In both cases addrLoad=0 and the burst type is kept.
- R9: On non-strobe edges of a write burst, wrMask follows the write-enable rule of R5. In a read burst, wrMask is 00 whatever the write enables are.
- R10: On edges with no accepted strobe, selHi and selLoN have no effect.
- R11: With no burst open, a non-strobe edge gives burstCont=0 and wrMask=00, and no burst is opened.
- R12: Every result is registered. It appears after the clock edge that sampled its inputs and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterSelN | input | 1 | Master chip select, active low; gates the processor strobe |
| selHi | input | 1 | Secondary chip select, active high |
| selLoN | input | 1 | Secondary chip select, active low |
| cpuStrobeN | input | 1 | Processor address strobe, active low |
| hostStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| allBytesWrN | input | 1 | Write-all-lanes enable, active low |
| laneWrEnN | input | 1 | Enables the per-lane selects, active low |
| laneSelN | input | 2 | Per-lane write selects, active low, bit i = lane i |
| addrLoad | output | 1 | One-cycle pulse: load a new external address |
| burstCont | output | 1 | One-cycle pulse: advance to the next burst address |
| wrMask | output | 2 | Per-lane internal write strobes for this cycle |
| wrBurst | output | 1 | 1 while the open burst is a write |

## Verification
Every output is due one clock edge after the edge that sampled the inputs causing it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a period after the deciding rising edge. Decisions that depend on the remembered burst type come from two-step sequences: a start edge, then continue or suspend edges. The later outputs are read one edge after each step, so an early or late state change shows up as a wrong pulse or mask.

// File: rtl/sramCmdPkg.sv
package sramCmdPkg;
  parameter int unsigned BYTE_LANES = 2;

  typedef enum logic [1:0] {
    BURST_IDLE  = 2'd0,
    BURST_READ  = 2'd1,
    BURST_WRITE = 2'd2
  } burstState_e;

  typedef struct packed {
    logic                  load;
    logic                  cont;
    logic                  wrBurst;
    logic [BYTE_LANES-1:0] wrMask;
  } cmdStrobe_t;
endpackage

// File: rtl/sramCmdCtl.sv
module sramCmdCtl
  import sramCmdPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  masterSelN,
  input  logic                  selHi,
  input  logic                  selLoN,
  input  logic                  cpuStrobeN,
  input  logic                  hostStrobeN,
  input  logic                  advanceN,
  input  logic                  allBytesWrN,
  input  logic                  laneWrEnN,
  input  logic [BYTE_LANES-1:0] laneSelN,
  output cmdStrobe_t            strobes
);
  burstState_e state, nextState;
  logic cpuHit, hostHit, startEdge, selected, anyWr;
  logic [BYTE_LANES-1:0] laneWr;

  // processor strobe counts only with master select; controller strobe only when processor is not taking the edge
  assign cpuHit    = !cpuStrobeN && !masterSelN;
  assign hostHit   = !hostStrobeN && !cpuHit;
  assign startEdge = cpuHit || hostHit;
  assign selected  = !masterSelN && selHi && !selLoN;

  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_lane
    assign laneWr[i] = !allBytesWrN || (!laneWrEnN && !laneSelN[i]);
  end
  assign anyWr = |laneWr;

  always_comb begin
    nextState = state;
    strobes   = '0;
    if (startEdge) begin
      if (!selected) begin
        nextState = BURST_IDLE;
      end else begin
        strobes.load = 1'b1;
        if (hostHit && anyWr) begin
          nextState      = BURST_WRITE;
          strobes.wrMask = laneWr;
        end else begin
          nextState = BURST_READ;
        end
      end
    end else if (state != BURST_IDLE) begin
      strobes.cont = !advanceN;
      if (state == BURST_WRITE) strobes.wrMask = laneWr;
    end
    strobes.wrBurst = (nextState == BURST_WRITE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= BURST_IDLE;
    else       state <= nextState;
  end

  // R2: processor-strobe start always opens a read burst
  a_r2_cpu_start_reads: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuStrobeN && !masterSelN && selHi && !selLoN) |=> (state == BURST_READ));
  // R4: controller strobe with master select inactive closes the burst
  a_r4_host_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (masterSelN && !hostStrobeN) |=> (state == BURST_IDLE));
  // R11: with no burst open, a non-strobe edge keeps it closed
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((state == BURST_IDLE) && hostStrobeN && (cpuStrobeN || masterSelN)) |=> (state == BURST_IDLE));
endmodule

// File: rtl/sramCmdPipe.sv
module sramCmdPipe
  import sramCmdPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  cmdStrobe_t            strobes,
  output logic                  addrLoad,
  output logic                  burstCont,
  output logic [BYTE_LANES-1:0] wrMask,
  output logic                  wrBurst
);
  cmdStrobe_t held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) held <= '0;
    else       held <= strobes;
  end

  assign addrLoad  = held.load;
  assign burstCont = held.cont;
  assign wrMask    = held.wrMask;
  assign wrBurst   = held.wrBurst;

  // R9: lane strobes only appear inside a write burst
  a_r9_mask_in_write: assert property (@(posedge clk) disable iff (!rstN)
    (|wrMask) |-> wrBurst);
  // R8: a load and an advance never coincide
  a_r8_load_or_cont: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({addrLoad, burstCont}));
  // R12: an advance pulse reflects a non-strobe decision of the previous edge
  a_r12_cont_registered: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cont && !strobes.load) |=> burstCont);
endmodule

// File: rtl/sramCmdDecoder.sv
module sramCmdDecoder
  import sramCmdPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  masterSelN,
  input  logic                  selHi,
  input  logic                  selLoN,
  input  logic                  cpuStrobeN,
  input  logic                  hostStrobeN,
  input  logic                  advanceN,
  input  logic                  allBytesWrN,
  input  logic                  laneWrEnN,
  input  logic [BYTE_LANES-1:0] laneSelN,
  output logic                  addrLoad,
  output logic                  burstCont,
  output logic [BYTE_LANES-1:0] wrMask,
  output logic                  wrBurst
);
  cmdStrobe_t strobes;

  sramCmdCtl uCtl (
    .clk(clk), .rstN(rstN), .masterSelN(masterSelN), .selHi(selHi), .selLoN(selLoN),
    .cpuStrobeN(cpuStrobeN), .hostStrobeN(hostStrobeN), .advanceN(advanceN),
    .allBytesWrN(allBytesWrN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
    .strobes(strobes)
  );

  sramCmdPipe uPipe (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrLoad(addrLoad),
    .burstCont(burstCont), .wrMask(wrMask), .wrBurst(wrBurst)
  );
endmodule

// File: tb/sim_sramCmdDecoder.sv
module sim_sramCmdDecoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterSelN, selHi, selLoN, cpuStrobeN, hostStrobeN, advanceN;
  logic allBytesWrN, laneWrEnN;
  logic [1:0] laneSelN;
  logic addrLoad, burstCont, wrBurst;
  logic [1:0] wrMask;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sramCmdDecoder u0 (
    .clk(clk), .rstN(rstN), .masterSelN(masterSelN), .selHi(selHi), .selLoN(selLoN),
    .cpuStrobeN(cpuStrobeN), .hostStrobeN(hostStrobeN), .advanceN(advanceN),
    .allBytesWrN(allBytesWrN), .laneWrEnN(laneWrEnN), .laneSelN(laneSelN),
    .addrLoad(addrLoad), .burstCont(burstCont), .wrMask(wrMask), .wrBurst(wrBurst)
  );

  task automatic quiet();
    masterSelN = 0; selHi = 1; selLoN = 0; cpuStrobeN = 1; hostStrobeN = 1;
    advanceN = 1; allBytesWrN = 1; laneWrEnN = 1; laneSelN = 2'b11;
  endtask

  // compare {addrLoad, burstCont, wrBurst, wrMask}
  task automatic expect5(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {addrLoad, burstCont, wrBurst, wrMask};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: load/cont/wr/mask actual %b expected %b", tag, act, exp);
    end
  endtask

  // inputs set after a falling edge; outputs read at the next falling edge (R12)
  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect5("R1 in reset", 5'b00000);
    @(negedge clk); rstN = 1;
    expect5("R1 after release", 5'b00000);
    quiet(); advanceN = 0; allBytesWrN = 0; step();
    expect5("R11 idle non-strobe", 5'b00000);
  endtask

  task automatic t_cpu_read();
    quiet(); cpuStrobeN = 0; hostStrobeN = 0; allBytesWrN = 0; step();
    expect5("R2 cpu start read", 5'b10000);
    quiet(); advanceN = 0; allBytesWrN = 0; step();
    expect5("R9 read burst ignores writes", 5'b01000);
    quiet(); advanceN = 1; step();
    expect5("R8 read suspend", 5'b00000);
    quiet(); advanceN = 0; step();
    expect5("R8 read kept after suspend", 5'b01000);
  endtask

  task automatic t_host_write();
    quiet(); hostStrobeN = 0; laneWrEnN = 0; laneSelN = 2'b10; step();
    expect5("R5 host start lane0", 5'b10101);
    quiet(); advanceN = 0; allBytesWrN = 0; step();
    expect5("R9 write cont all lanes", 5'b01111);
    quiet(); selHi = 0; selLoN = 1; advanceN = 0; laneWrEnN = 0; laneSelN = 2'b01; step();
    expect5("R10 selects ignored lane1", 5'b01110);
    quiet(); step();
    expect5("R8 write suspend", 5'b00100);
    quiet(); hostStrobeN = 0; allBytesWrN = 0; step();
    expect5("R5 host start all lanes", 5'b10111);
  endtask

  task automatic t_host_read();
    quiet(); hostStrobeN = 0; laneWrEnN = 0; laneSelN = 2'b11; step();
    expect5("R6 host start no lane", 5'b10000);
    quiet(); hostStrobeN = 0; laneWrEnN = 1; laneSelN = 2'b00; step();
    expect5("R6 lane selects without enable", 5'b10000);
  endtask

  task automatic t_master_gate();
    quiet(); cpuStrobeN = 0; step();
    quiet(); masterSelN = 1; cpuStrobeN = 0; advanceN = 0; step();
    expect5("R3 blocked cpu strobe continues", 5'b01000);
    quiet(); masterSelN = 1; hostStrobeN = 0; allBytesWrN = 0; step();
    expect5("R4 host strobe deselects", 5'b00000);
    quiet(); advanceN = 0; step();
    expect5("R4 burst closed", 5'b00000);
  endtask

  task automatic t_deselect();
    quiet(); hostStrobeN = 0; allBytesWrN = 0; step();
    quiet(); hostStrobeN = 0; selHi = 0; allBytesWrN = 0; step();
    expect5("R7 selHi low deselects", 5'b00000);
    quiet(); advanceN = 0; allBytesWrN = 0; step();
    expect5("R7 closed after deselect", 5'b00000);
    quiet(); cpuStrobeN = 0; step();
    quiet(); cpuStrobeN = 0; selLoN = 1; step();
    expect5("R7 selLoN high deselects", 5'b00000);
    quiet(); advanceN = 0; step();
    expect5("R11 no advance while idle", 5'b00000);
  endtask

  initial begin
    quiet();
    repeat (2) @(negedge clk);
    t_reset();
    t_cpu_read();
    t_host_write();
    t_host_read();
    t_master_gate();
    t_deselect();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule